// File: doc/BRIEF.md
# Cross-Module Check-Routine Address Resolver

This block sits on the slow path of a control-flow check that crosses module boundaries. It takes a call-target address and a 64-bit call-site type identifier, reads a 16-bit shadow entry for the 4 KiB page that holds the target, and decides what the target is. A shadow entry of zero means the page has no valid call target. The all-ones entry means the page belongs to a trusted module that is not checked. Any other value V means the page is in an instrumented module. For those pages the block computes where that module's check routine sits: the target rounded up to the next page boundary, minus V+1 pages.

The shadow table is a separate synchronous memory with a one-cycle read latency. The block issues the read in the cycle the request arrives, using the page number of the target as the index. The response comes one cycle later. It carries a class code, the routine address (zero unless routed) and the type identifier, which is passed through unchanged. Filling the table and running the check routine are handled elsewhere.

Top module: `chk_route_resolver`

## Requirements
- R1: While reset is held low at a clock edge, `rsp_valid` is 0 in the following cycle.
- R2: In the cycle `req_valid` is 1, `shd_rd_en` is 1 and `shd_rd_idx` equals `req_addr` shifted right by 12 (the page number). When `req_valid` is 0, `shd_rd_en` is 0.
- R3: `rsp_valid` is 1 exactly one cycle after a request. `rsp_type` then equals that request's `req_type`.
- R4: Class codes on `rsp_class` are 0 = invalid, 1 = trusted, 2 = routed. A shadow value of 0x0000 gives class 0 and `rsp_routine` 0.
- R5: A shadow value of 0xFFFF gives class 1 and `rsp_routine` 0. No address is computed.
- R6: For any other shadow value V, the class is 2 and `rsp_routine` = AlignUp(target) − (V+1)·4096. AlignUp leaves a page-aligned target unchanged and otherwise rounds it up to the next multiple of 4096. This includes a target in the last page of the address space, whose rounded value is 2^48.
- R7: A routed `rsp_routine` has its low 12 bits zero, is not above the target, and lies no more than 2^28 bytes below it.
- R8: If AlignUp(target) < (V+1)·4096, the subtraction would go below zero. The class is then 0 and `rsp_routine` is 0. A result that breaks the R7 distance limit is also reported as class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | 48 | Call-target address |
| req_type | input | 64 | Call-site type identifier |
| shd_rd_en | output | 1 | Shadow memory read enable |
| shd_rd_idx | output | 36 | Shadow entry index (page number) |
| shd_rd_data | input | 16 | Shadow entry, valid the cycle after the read |
| rsp_valid | output | 1 | Response is valid |
| rsp_class | output | 2 | 0 invalid, 1 trusted, 2 routed |
| rsp_routine | output | 48 | Check-routine address when routed, else 0 |
| rsp_type | output | 64 | Type identifier of the request being answered |

## Verification
The assertions check the following on every cycle: the read is issued with the request, the response follows one cycle later with the same type identifier, and the two reserved shadow values map to their classes. They also check that any routed address is page-aligned, not above the target and within the distance limit. They cannot show that the routed address is the exact value of the page arithmetic, or that a borderline subtraction is classed correctly. Only the bench's scenarios can show those: targets aligned and unaligned, a result of exactly zero, a subtraction one page short, the largest legal V, and the last page of the address space, compared against a reference computed in the bench.

// File: rtl/crr_pkg.sv
// Shared definitions for the check-routine resolver.
// Assumes: class codes are fixed by the response interface.
package crr_pkg;
    typedef enum logic [1:0] {
        CLS_INVALID = 2'd0,
        CLS_TRUSTED = 2'd1,
        CLS_ROUTED  = 2'd2
    } crr_class_e;
endpackage

// File: rtl/crr_align_up.sv
// Rounds an address up to the next page boundary.
// Assumes: the output is one bit wider than the input, so the last page
// of the address space rounds to 2^ADDR_W without wrapping.
module crr_align_up #(
    parameter int ADDR_W     = 48,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W:0]   aligned
);
    localparam int PW = ADDR_W - PAGE_SHIFT + 1;

    logic [PW-1:0] page_up;

    // page number, bumped when any offset bit is set
    assign page_up = {1'b0, addr[ADDR_W-1:PAGE_SHIFT]} + PW'(|addr[PAGE_SHIFT-1:0]);
    assign aligned = {page_up, {PAGE_SHIFT{1'b0}}};
endmodule

// File: rtl/crr_route_calc.sv
// Computes aligned - (v+1) pages and judges whether the result is usable.
// Assumes: ADDR_W+1 >= SHADOW_W+1+PAGE_SHIFT, so the offset never truncates.
module crr_route_calc #(
    parameter int ADDR_W     = 48,
    parameter int PAGE_SHIFT = 12,
    parameter int SHADOW_W   = 16,
    parameter int SPAN_SHIFT = 28
) (
    input  logic [ADDR_W:0]     aligned,
    input  logic [ADDR_W-1:0]   target,
    input  logic [SHADOW_W-1:0] shadow,
    output logic [ADDR_W-1:0]   routine,
    output logic                usable
);
    localparam int XW = ADDR_W + 1;
    localparam logic [XW-1:0] SPAN_MAX = XW'(1) << SPAN_SHIFT;

    logic [XW-1:0] offset;
    logic [XW-1:0] diff;
    logic [XW-1:0] span;
    logic          underflow;
    logic          above;
    logic          too_far;

    // offset of the routine below the aligned target, in bytes
    assign offset    = (XW'(shadow) + XW'(1)) << PAGE_SHIFT;
    // raw subtraction and its validity conditions
    assign underflow = offset > aligned;
    assign diff      = aligned - offset;
    assign above     = diff > {1'b0, target};
    assign span      = {1'b0, target} - diff;
    assign too_far   = span > SPAN_MAX;
    assign usable    = !underflow && !above && !too_far;
    assign routine   = diff[ADDR_W-1:0];
endmodule

// File: rtl/chk_route_resolver.sv
// Resolves a call target to the check routine of its owning module via a
// page-granular shadow table.
// Assumes: the shadow memory returns data one cycle after shd_rd_en.
module chk_route_resolver
    import crr_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int PAGE_SHIFT = 12,
    parameter int SHADOW_W   = 16,
    parameter int TYPE_W     = 64,
    parameter int SPAN_SHIFT = 28,
    localparam int IDX_W     = ADDR_W - PAGE_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [TYPE_W-1:0]   req_type,
    output logic                shd_rd_en,
    output logic [IDX_W-1:0]    shd_rd_idx,
    input  logic [SHADOW_W-1:0] shd_rd_data,
    output logic                rsp_valid,
    output logic [1:0]          rsp_class,
    output logic [ADDR_W-1:0]   rsp_routine,
    output logic [TYPE_W-1:0]   rsp_type
);
    localparam logic [SHADOW_W-1:0] SHD_INVALID = '0;
    localparam logic [SHADOW_W-1:0] SHD_TRUSTED = '1;

    logic [ADDR_W-1:0] addr_q;
    logic [TYPE_W-1:0] type_q;
    logic              vld_q;
    logic [ADDR_W:0]   aligned;
    logic [ADDR_W-1:0] routine;
    logic              usable;

    // issue the shadow read in the request cycle
    assign shd_rd_en  = req_valid;
    assign shd_rd_idx = req_addr[ADDR_W-1:PAGE_SHIFT];

    // hold the request while the shadow entry is fetched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
            type_q <= '0;
        end else begin
            vld_q <= req_valid;
            if (req_valid) begin
                addr_q <= req_addr;
                type_q <= req_type;
            end
        end
    end

    crr_align_up #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_align (
        .addr   (addr_q),
        .aligned(aligned)
    );

    crr_route_calc #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .SHADOW_W  (SHADOW_W),
        .SPAN_SHIFT(SPAN_SHIFT)
    ) u_calc (
        .aligned(aligned),
        .target (addr_q),
        .shadow (shd_rd_data),
        .routine(routine),
        .usable (usable)
    );

    // classify the returned shadow entry
    always_comb begin
        rsp_class   = CLS_INVALID;
        rsp_routine = '0;
        if (shd_rd_data == SHD_TRUSTED) begin
            rsp_class = CLS_TRUSTED;
        end else if (shd_rd_data != SHD_INVALID && usable) begin
            rsp_class   = CLS_ROUTED;
            rsp_routine = routine;
        end
    end

    assign rsp_valid = vld_q;
    assign rsp_type  = type_q;
endmodule

// File: rtl/crr_checker.sv
// Temporal checks on the resolver's ports, bound to every instance.
// Assumes: synchronous active-low reset.
module crr_checker #(
    parameter int ADDR_W     = 48,
    parameter int PAGE_SHIFT = 12,
    parameter int SHADOW_W   = 16,
    parameter int TYPE_W     = 64,
    parameter int SPAN_SHIFT = 28,
    localparam int IDX_W     = ADDR_W - PAGE_SHIFT
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [TYPE_W-1:0]   req_type,
    input logic                shd_rd_en,
    input logic [IDX_W-1:0]    shd_rd_idx,
    input logic [SHADOW_W-1:0] shd_rd_data,
    input logic                rsp_valid,
    input logic [1:0]          rsp_class,
    input logic [ADDR_W-1:0]   rsp_routine,
    input logic [TYPE_W-1:0]   rsp_type
);
    localparam logic [ADDR_W:0] SPAN_MAX = (ADDR_W+1)'(1) << SPAN_SHIFT;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

    // R2
    read_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (shd_rd_en && shd_rd_idx == req_addr[ADDR_W-1:PAGE_SHIFT]));

    // R3
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid && rsp_type == $past(req_type)));

    // R4
    invalid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && shd_rd_data == '0) |-> (rsp_class == 2'd0 && rsp_routine == '0));

    // R5
    trusted_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && shd_rd_data == '1) |-> (rsp_class == 2'd1 && rsp_routine == '0));

    // R7
    routed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_class == 2'd2) |->
            (rsp_routine[PAGE_SHIFT-1:0] == '0 && rsp_routine <= $past(req_addr)
             && ({1'b0, $past(req_addr)} - {1'b0, rsp_routine}) <= SPAN_MAX));
endmodule

bind chk_route_resolver crr_checker #(
    .ADDR_W    (ADDR_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .SHADOW_W  (SHADOW_W),
    .TYPE_W    (TYPE_W),
    .SPAN_SHIFT(SPAN_SHIFT)
) u_crr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_type   (req_type),
    .shd_rd_en  (shd_rd_en),
    .shd_rd_idx (shd_rd_idx),
    .shd_rd_data(shd_rd_data),
    .rsp_valid  (rsp_valid),
    .rsp_class  (rsp_class),
    .rsp_routine(rsp_routine),
    .rsp_type   (rsp_type)
);

// File: tb/test_chk_route_resolver.sv
`timescale 1ns/1ps
module test_chk_route_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [47:0] req_addr = '0;
    logic [63:0] req_type = '0;
    logic        shd_rd_en;
    logic [35:0] shd_rd_idx;
    logic [15:0] shd_rd_data = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_class;
    logic [47:0] rsp_routine;
    logic [63:0] rsp_type;

    int unsigned n_run = 0;
    int unsigned n_fail = 0;
    logic [15:0] cur_v = '0;

    always #2 clk = ~clk;

    chk_route_resolver i_chk_route_resolver (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_type(req_type), .shd_rd_en(shd_rd_en), .shd_rd_idx(shd_rd_idx),
        .shd_rd_data(shd_rd_data), .rsp_valid(rsp_valid), .rsp_class(rsp_class),
        .rsp_routine(rsp_routine), .rsp_type(rsp_type)
    );

    // shadow memory model: one-cycle read latency
    always @(posedge clk) if (shd_rd_en) shd_rd_data <= cur_v;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference built from the requirements (R4..R8)
    function automatic void ref_model(input logic [47:0] a, input logic [15:0] v,
                                      output logic [1:0] c, output logic [47:0] r);
        logic [63:0] au, off, res;
        au  = ({16'd0, a} + 64'd4095) & ~64'd4095;
        off = ({48'd0, v} + 64'd1) << 12;
        c = 2'd0;
        r = '0;
        if (v == 16'hFFFF) c = 2'd1;
        else if (v != 16'h0 && off <= au) begin
            res = au - off;
            if (res <= {16'd0, a} && ({16'd0, a} - res) <= 64'h1000_0000) begin
                c = 2'd2;
                r = res[47:0];
            end
        end
    endfunction

    task automatic do_req(input logic [47:0] a, input logic [15:0] v, input logic [63:0] t, input string tag);
        logic [1:0]  ec;
        logic [47:0] er;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_type  = t;
        cur_v     = v;
        #0.5;
        check(shd_rd_en == 1'b1, {"R2 rd_en ", tag}, 64'(shd_rd_en), 64'd1);
        check(shd_rd_idx == a[47:12], {"R2 idx ", tag}, 64'(shd_rd_idx), 64'(a[47:12]));
        @(negedge clk);
        req_valid = 1'b0;
        ref_model(a, v, ec, er);
        check(rsp_valid == 1'b1, {"R3 valid ", tag}, 64'(rsp_valid), 64'd1);
        check(rsp_type == t, {"R3 type ", tag}, rsp_type, t);
        check(rsp_class == ec, {"R4 R5 R8 class ", tag}, 64'(rsp_class), 64'(ec));
        check(rsp_routine == er, {"R6 R7 routine ", tag}, 64'(rsp_routine), 64'(er));
        #0.5;
        check(shd_rd_en == 1'b0, {"R2 idle ", tag}, 64'(shd_rd_en), 64'd0);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] a;
        logic [15:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: response quiet in reset
        check(rsp_valid == 1'b0, "R1 reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        // R4 invalid entry
        do_req(48'h0000_1234_5678, 16'h0000, 64'h1111, "zero entry");
        // R5 trusted entry
        do_req(48'h0000_8000_0001, 16'hFFFF, 64'h2222, "trusted");
        // R6 aligned target unchanged by AlignUp
        do_req(48'h0000_0010_0000, 16'h0003, 64'h3333, "aligned");
        // R6 unaligned target rounds up
        do_req(48'h0000_0010_0001, 16'h0003, 64'h4444, "unaligned");
        // R6 result exactly zero
        do_req(48'h0000_0000_6000, 16'h0005, 64'h5555, "zero result");
        // R8 one page short
        do_req(48'h0000_0000_5000, 16'h0005, 64'h6666, "underflow");
        // R8 smallest target
        do_req(48'h0, 16'h0001, 64'h7777, "addr zero");
        // R7 largest legal V
        do_req(48'h0000_4000_0FFF, 16'hFFFE, 64'h8888, "max V");
        // R6 last page of address space
        do_req(48'hFFFF_FFFF_FFFF, 16'h0001, 64'h9999, "top page");
        // random mix
        for (int i = 0; i < 300; i++) begin
            a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            if (i % 3 == 0) a = a & 48'h0000_0FFF_FFFF;
            case ($urandom % 5)
                0: v = 16'h0000;
                1: v = 16'hFFFF;
                2: v = 16'($urandom % 16);
                default: v = 16'($urandom);
            endcase
            do_req(a, v, {$urandom, $urandom}, "random");
        end
        // R1 reset mid-run clears response
        @(negedge clk);
        req_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b0, "R1 reset mid-run", 64'(rsp_valid), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule